// File: doc/BRIEF.md
# Protected Low-Side Channel Supervisor

This block is the digital control and fault supervisor for one protected low-side load driver, such as a fuel injector or relay channel. It takes a command from a controller together with status flags from the analog front end: a drain comparator (drain voltage above the fault threshold), an over-temperature flag, and supply over-voltage and under-voltage flags. From these it produces the gate enable for the power device and a single fault flag back to the controller.

The command is brought into the clock domain through a synchronizer, and its rising edges are detected there. Two persistence filters qualify the drain comparator. The first catches a short to battery, which shows as the drain staying high while the device is on. The second catches an open load, which shows as the drain staying low while the device is off. A qualified short or an over-voltage event latches the channel off. A qualified fault holds the fault flag high. Both the channel and the flag re-arm only on a fresh rising edge of the command. Over-temperature and under-voltage inhibit the gate only while they last. Current limiting, the clamp and the comparators are analog and are not part of this block.

Top module: `lsd_fault_sup`

## Requirements
- R1: After reset, gate_en and fault are both 0.
- R2: With no fault cause present, gate_en follows cmd_in with a latency of three clock edges, in both directions.
- R3: While gate_en is 1, cmd is high and drain_hi is 1 for SHORT_TICKS consecutive edges, gate_en goes to 0 and fault goes to 1 on that edge. A drain_hi burst that is even one cycle shorter has no effect, because the filter restarts from zero whenever drain_hi drops.
- R4: While the synchronized command is low and drain_hi is 0 for OPEN_TICKS consecutive edges, fault goes to 1 on that edge. A shorter burst has no effect, and gate_en stays 0 throughout.
- R5: Once fault is 1, it stays 1 while the command stays high or stays low. It returns to 0 three edges after a rising edge of cmd_in, provided no fault cause is present at that time.
- R6: After a short-to-battery shutdown, gate_en stays 0 while cmd_in remains high. It turns on again only after cmd_in goes low and then high.
- R7: ot_flag forces gate_en to 0 on the next edge, regardless of the command, and sets fault on that same edge. When ot_flag clears while the command is still high, gate_en returns on the next edge without a command toggle.
- R8: ov_flag forces gate_en to 0 on the next edge and latches the channel off. A command rising edge that occurs while ov_flag is still 1 does not re-arm the channel. Recovery needs ov_flag to be 0 and then a new command rising edge. ov_flag does not set fault.
- R9: uv_flag holds gate_en at 0 only while it is asserted. gate_en returns on the first edge after uv_flag clears. uv_flag does not set fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_in | input | 1 | Asynchronous on/off command from the controller |
| drain_hi | input | 1 | Comparator flag: drain voltage is above the fault threshold |
| ot_flag | input | 1 | Output device over-temperature |
| ov_flag | input | 1 | Supply over-voltage |
| uv_flag | input | 1 | Supply under-voltage |
| gate_en | output | 1 | Gate enable for the low-side power device |
| fault | output | 1 | Sticky fault flag to the controller |

## Verification
The assertions check the following rules on every cycle:
- Each inhibit flag (over-temperature, over-voltage, under-voltage) holds the gate off on the next edge.
- A gate that is on always traces back to a high command three edges earlier.
- The fault flag never drops right after an over-temperature sample.

The following behaviours depend on how long a condition has lasted, so only the bench scenarios can show them:
- The exact edge on which each persistence filter expires, and the restart of the filter after a burst that falls one cycle short.
- The latched-off state after a short, which holds until the command toggles.
- The refusal to re-arm on a command edge that arrives during over-voltage.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    // Registered state of the channel controller
    typedef struct packed {
        logic armed;   // channel allowed to drive when commanded
        logic gate;    // gate enable to the power device
        logic flt;     // sticky fault flag
    } sup_state_t;

    localparam sup_state_t SUP_RESET = '{armed: 1'b0, gate: 1'b0, flt: 1'b0};

endpackage

// File: rtl/lsd_cmd_sync.sv
module lsd_cmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sh_q, sh_d;
    logic              prev_q, prev_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign sh_d[g] = async_i;
            end else begin : g_next
                assign sh_d[g] = sh_q[g-1];
            end
        end
    endgenerate

    assign prev_d = sh_q[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign sync_o = sh_q[LAST];
    assign rise_o = sh_q[LAST] & ~prev_q;

endmodule

// File: rtl/lsd_qual_filter.sv
module lsd_qual_filter #(
    parameter int LIMIT = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    output logic done_o
);
    localparam int            CW       = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          at_last;

    assign at_last = (cnt_q == CNT_LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!cond_i) begin
            cnt_d = '0;
        end else if (!at_last) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Condition has now been present for LIMIT consecutive edges
    assign done_o = cond_i & at_last;

endmodule

// File: rtl/lsd_fault_sup.sv
module lsd_fault_sup
    import lsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_TICKS = 6000,
    parameter int OPEN_TICKS  = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_in,
    input  logic drain_hi,
    input  logic ot_flag,
    input  logic ov_flag,
    input  logic uv_flag,
    output logic gate_en,
    output logic fault
);
    sup_state_t st_q, st_d;

    logic cmd_s, cmd_rise;
    logic short_cond, open_cond;
    logic short_hit, open_hit;
    logic inhibit;

    lsd_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmd_in),
        .sync_o  (cmd_s),
        .rise_o  (cmd_rise)
    );

    // Short: device driven on but the drain stays high
    assign short_cond = cmd_s & st_q.gate & drain_hi;
    // Open load: device off but the drain is pulled low
    assign open_cond  = ~cmd_s & ~drain_hi;

    lsd_qual_filter #(.LIMIT(SHORT_TICKS)) u_short_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (short_cond),
        .done_o (short_hit)
    );

    lsd_qual_filter #(.LIMIT(OPEN_TICKS)) u_open_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (open_cond),
        .done_o (open_hit)
    );

    assign inhibit = ot_flag | ov_flag | uv_flag;

    always_comb begin
        st_d = st_q;
        // Latch-off causes have priority over re-arming
        if (short_hit || ov_flag) begin
            st_d.armed = 1'b0;
        end else if (cmd_rise) begin
            st_d.armed = 1'b1;
        end
        st_d.gate = cmd_s & st_d.armed & ~inhibit;
        // Set beats clear: a cause still present keeps the flag up
        st_d.flt  = short_hit | open_hit | ot_flag | (st_q.flt & ~cmd_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SUP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_en = st_q.gate;
    assign fault   = st_q.flt;

endmodule

// File: rtl/lsd_sup_chk.sv
module lsd_sup_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_in,
    input logic ot_flag,
    input logic ov_flag,
    input logic uv_flag,
    input logic gate_en,
    input logic fault
);
    // R7
    ot_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> !gate_en);

    // R7
    ot_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> fault);

    // R8
    ov_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flag |=> !gate_en);

    // R9
    uv_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> !gate_en);

    // R2
    gate_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> $past(cmd_in, 3));

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> !$past(ot_flag));

endmodule

bind lsd_fault_sup lsd_sup_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_in  (cmd_in),
    .ot_flag (ot_flag),
    .ov_flag (ov_flag),
    .uv_flag (uv_flag),
    .gate_en (gate_en),
    .fault   (fault)
);

// File: tb/sim_lsd_fault_sup.sv
`timescale 1ns/1ps
module sim_lsd_fault_sup;
    localparam int S = 8;
    localparam int O = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_in = 1'b0, drain_hi = 1'b1;
    logic ot_flag = 1'b0, ov_flag = 1'b0, uv_flag = 1'b0;
    logic gate_en, fault;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lsd_fault_sup #(.SYNC_STAGES(2), .SHORT_TICKS(S), .OPEN_TICKS(O)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .drain_hi(drain_hi),
        .ot_flag(ot_flag), .ov_flag(ov_flag), .uv_flag(uv_flag),
        .gate_en(gate_en), .fault(fault)
    );

    // Reference model built from the requirements
    logic m_s1, m_s2, m_prev, m_armed, m_gate, m_flt;
    int   m_sc, m_oc;

    function automatic int next_cnt(input logic c, input int cnt, input int lim);
        if (!c) return 0;
        return (cnt < lim - 1) ? cnt + 1 : cnt;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_armed = 0; m_gate = 0; m_flt = 0;
            m_sc = 0; m_oc = 0;
        end else begin
            logic rise, sc, oc, sd, od, an;
            rise = m_s2 & ~m_prev;
            sc = m_s2 & m_gate & drain_hi;
            oc = ~m_s2 & ~drain_hi;
            sd = sc && (m_sc == S - 1);
            od = oc && (m_oc == O - 1);
            an = (sd | ov_flag) ? 1'b0 : (rise ? 1'b1 : m_armed);
            m_flt   = sd | od | ot_flag | (m_flt & ~rise);
            m_gate  = m_s2 & an & ~ot_flag & ~ov_flag & ~uv_flag;
            m_armed = an;
            m_sc = next_cnt(sc, m_sc, S);
            m_oc = next_cnt(oc, m_oc, O);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = cmd_in;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        step(3);
        chk("R1 gate after reset", gate_en, 1'b0);
        chk("R1 fault after reset", fault, 1'b0);
        rst_n = 1'b1;
        step(2);
        chk("R1 gate idle", gate_en, 1'b0);

        // R2 latency both ways
        cmd_in = 1; drain_hi = 0;
        step(2); chk("R2 gate not yet on", gate_en, 1'b0);
        step(1); chk("R2 gate on", gate_en, 1'b1);
        cmd_in = 0; drain_hi = 1;
        step(2); chk("R2 gate not yet off", gate_en, 1'b1);
        step(1); chk("R2 gate off", gate_en, 1'b0);

        // R3 short filter, with a burst one cycle short
        cmd_in = 1; drain_hi = 0;
        step(3); chk("R3 gate on", gate_en, 1'b1);
        drain_hi = 1; step(S - 1);
        chk("R3 short burst no fault", fault, 1'b0);
        chk("R3 short burst gate on", gate_en, 1'b1);
        drain_hi = 0; step(1);
        drain_hi = 1; step(S - 1);
        chk("R3 filter restarted", fault, 1'b0);
        step(1);
        chk("R3 short fault", fault, 1'b1);
        chk("R3 short gate off", gate_en, 1'b0);

        // R6 latched off while command held high
        step(10);
        chk("R6 stays off", gate_en, 1'b0);
        chk("R5 fault held high cmd", fault, 1'b1);
        cmd_in = 0; step(5);
        chk("R5 fault held low cmd", fault, 1'b1);
        cmd_in = 1; drain_hi = 0;
        step(2); chk("R5 fault before rearm", fault, 1'b1);
        step(1);
        chk("R6 rearmed gate", gate_en, 1'b1);
        chk("R5 fault cleared", fault, 1'b0);

        // R4 open load while off
        cmd_in = 0; drain_hi = 0;
        step(21);
        chk("R4 no fault yet", fault, 1'b0);
        step(1);
        chk("R4 open fault", fault, 1'b1);
        chk("R4 gate off", gate_en, 1'b0);
        step(5); chk("R4 fault held", fault, 1'b1);
        cmd_in = 1; step(3);
        chk("R4 gate back", gate_en, 1'b1);
        chk("R5 open fault cleared", fault, 1'b0);

        // R7 over-temperature
        ot_flag = 1; step(1);
        chk("R7 gate off", gate_en, 1'b0);
        chk("R7 fault set", fault, 1'b1);
        step(3); chk("R7 held off", gate_en, 1'b0);
        ot_flag = 0; step(1);
        chk("R7 resumes", gate_en, 1'b1);
        chk("R5 ot fault sticky", fault, 1'b1);
        cmd_in = 0; drain_hi = 1; step(3);
        cmd_in = 1; drain_hi = 0; step(3);
        chk("R5 ot fault cleared", fault, 1'b0);

        // R8 over-voltage
        ov_flag = 1; step(1);
        chk("R8 gate off", gate_en, 1'b0);
        chk("R8 no fault", fault, 1'b0);
        ov_flag = 0; step(3);
        chk("R8 latched", gate_en, 1'b0);
        ov_flag = 1; cmd_in = 0; drain_hi = 1; step(3);
        cmd_in = 1; drain_hi = 0; step(4);
        ov_flag = 0; step(3);
        chk("R8 edge during ov ignored", gate_en, 1'b0);
        cmd_in = 0; drain_hi = 1; step(3);
        cmd_in = 1; drain_hi = 0; step(3);
        chk("R8 recovered", gate_en, 1'b1);
        chk("R8 fault still clear", fault, 1'b0);

        // R9 under-voltage
        uv_flag = 1; step(1);
        chk("R9 gate off", gate_en, 1'b0);
        chk("R9 no fault", fault, 1'b0);
        uv_flag = 0; step(1);
        chk("R9 resumes", gate_en, 1'b1);

        // Random phase against the model (R2 R3 R4 R5 R6 R7 R8 R9)
        begin
            int dmode = 0;
            for (int i = 0; i < 4000; i++) begin
                @(negedge clk);
                chk("random gate R2 R3 R6 R7 R8 R9", gate_en, m_gate);
                chk("random fault R3 R4 R5 R7", fault, m_flt);
                if ($urandom_range(0, 29) == 0) cmd_in = ~cmd_in;
                if (i % 12 == 0) dmode = $urandom_range(0, 3);
                drain_hi = (dmode <= 1) ? ~m_gate : (dmode == 2);
                if (ot_flag ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 199) == 0)) ot_flag = ~ot_flag;
                if (ov_flag ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 199) == 0)) ov_flag = ~ov_flag;
                if (uv_flag ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 199) == 0)) uv_flag = ~uv_flag;
            end
        end
        finish_run();
    end
endmodule